// File: doc/BRIEF.md
# ECC Error Injection Controller

This block lets privileged software deliberately corrupt the check bits of one entry in a cache, either in the tag array or in the data array. The next read of that entry then trips the ECC checker. Software sees two 64-bit registers behind a simple read/write port. The control word sits at offset 0x00 and the target physical address sits at offset 0x08. Software writes the address, then writes the control word with the check enable, a target code and the trigger bit set.

The block screens the request straight away. A request with the checker disabled, or with a reserved target code, fails at once. A valid request sends one lookup to the cache over a valid/ready handshake. The cache answers with hit or miss and, on a hit, the set and way that hold the line. On a hit the block raises a one-cycle write strobe toward the chosen array at that set and way. The outcome is sticky: "injected" or "error", with a coded reason on error. The outcome stays until software reads the control word, and then the status drops back to idle.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, both registers read zero, `lk_req_valid`, `inj_we` and `ecc_check_en` are low.
- R2: Control word layout: bit 0 is the check enable (read/write, also driven on `ecc_check_en`). Bits 3:2 are the target (read/write; 0 tag array, 2 data array, 1 and 3 reserved). Bit 1 is the trigger and always reads 0. Bits 6:4 are the status. Bits 9:7 are the reason. Bits 63:10 read 0.
- R3: The address word at offset 0x08 stores the low PADDR_BITS bits of a write, and its upper bits read 0. Offsets other than 0x00 and 0x08 read 0.
- R4: A trigger written with enable 0 sets status 7 (error) with reason 0 on the next cycle, and issues no lookup. This takes priority over a reserved target.
- R5: A trigger with enable 1 and target 1 or 3 sets status 7 with reason 1 on the next cycle, and issues no lookup.
- R6: A trigger with enable 1 and target 0 or 2 sets status 1 (working) and raises `lk_req_valid` on the next cycle. `lk_req_valid` and `lk_req_paddr` (equal to the address word) are held until `lk_req_ready`.
- R7: A hit response makes `inj_we` high for exactly one cycle, on the cycle after the response. With it, `inj_set` and `inj_way` carry the response values and `inj_data_sel` is 1 for target 2 and 0 for target 0. The status becomes 2 (injected).
- R8: A miss response sets status 7 with reason 2, and `inj_we` stays low.
- R9: A read of the control word while the status is 2 or 7 returns that status, and later reads show status 0. The reason field reads 0 whenever the status is not 7.
- R10: A trigger while the status is not 0 is ignored. Writes to enable and target are accepted while the status is 2 or 7. All writes to either register are ignored while the status is 1.
- R11: The status field only ever takes the values 0, 1, 2 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (a control read clears a finished status) |
| reg_addr | input | OFS_BITS | Byte offset within the block window |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from `reg_addr` |
| ecc_check_en | output | 1 | Check enable toward the ECC checker |
| lk_req_valid | output | 1 | Lookup request valid |
| lk_req_ready | input | 1 | Lookup request accepted |
| lk_req_paddr | output | PADDR_BITS | Physical address to look up |
| lk_resp_valid | input | 1 | Lookup response valid |
| lk_resp_hit | input | 1 | Address is resident |
| lk_resp_set | input | SET_BITS | Set holding the line |
| lk_resp_way | input | WAY_BITS | Way holding the line |
| inj_we | output | 1 | One-cycle check-bit corruption strobe |
| inj_data_sel | output | 1 | 1 selects the data array, 0 the tag array |
| inj_set | output | SET_BITS | Set to corrupt |
| inj_way | output | WAY_BITS | Way to corrupt |

## Verification
A wrong internal state shows first in the status field of the control word. For example, the block might stay in working, skip to injected without a strobe, or clear before a read. That field can be read on any cycle, so the bench reads it right after each step of every scenario. A corrupted lookup phase shows in the cycle it happens: `lk_req_valid` drops before `lk_req_ready`, appears after a screened failure, or reappears after an ignored trigger. A bad hit path shows one cycle after the response, as a missing, doubled or misdirected `inj_we`.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int REG_W    = 64;
    localparam int EN_BIT   = 0;
    localparam int TRIG_BIT = 1;
    localparam int TGT_LO   = 2;
    localparam int ST_LO    = 4;
    localparam int RSN_LO   = 7;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WORK = 3'd1,
        ST_DONE = 3'd2,
        ST_FAIL = 3'd7
    } inj_status_e;

    typedef enum logic [2:0] {
        RSN_NOCHK  = 3'd0,
        RSN_BADTGT = 3'd1,
        RSN_MISS   = 3'd2
    } inj_reason_e;

    typedef enum logic [1:0] {
        TGT_META = 2'd0,
        TGT_RSV1 = 2'd1,
        TGT_DATA = 2'd2,
        TGT_RSV3 = 2'd3
    } inj_target_e;

    typedef struct packed {
        logic        fire;
        logic        en;
        inj_target_e tgt;
    } trig_req_t;

    function automatic logic target_reserved(inj_target_e t);
        return t[0];
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(logic en, inj_target_e t,
                                                   inj_status_e s, inj_reason_e r);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]             = en;
        w[TGT_LO +: 2]        = t;
        w[ST_LO +: 3]         = s;
        w[RSN_LO +: 3]        = (s == ST_FAIL) ? r : RSN_NOCHK;
        return w;
    endfunction

endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
    import ecc_inj_pkg::*;
#(
    parameter int PADDR_BITS = 48,
    parameter int OFS_BITS   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [OFS_BITS-1:0]   addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic                  busy,
    input  inj_status_e           status,
    input  inj_reason_e           reason,
    output trig_req_t             trig,
    output logic                  ctrl_rd,
    output logic                  en_q,
    output inj_target_e           tgt_q,
    output logic [PADDR_BITS-1:0] paddr_q
);
    localparam logic [OFS_BITS-1:0] CTRL_OFS = OFS_BITS'(0);
    localparam logic [OFS_BITS-1:0] ADDR_OFS = OFS_BITS'(8);

    logic sel_ctrl, sel_addr;
    assign sel_ctrl = (addr == CTRL_OFS);
    assign sel_addr = (addr == ADDR_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            tgt_q   <= TGT_META;
            paddr_q <= '0;
        end else if (wr_en && !busy) begin
            if (sel_ctrl) begin
                en_q  <= wdata[EN_BIT];
                tgt_q <= inj_target_e'(wdata[TGT_LO +: 2]);
            end
            if (sel_addr) begin
                paddr_q <= wdata[PADDR_BITS-1:0];
            end
        end
    end

    always_comb begin
        trig.fire = wr_en && sel_ctrl && wdata[TRIG_BIT];
        trig.en   = wdata[EN_BIT];
        trig.tgt  = inj_target_e'(wdata[TGT_LO +: 2]);
    end

    assign ctrl_rd = rd_en && sel_ctrl;

    always_comb begin
        if (sel_ctrl)      rdata = pack_ctrl(en_q, tgt_q, status, reason);
        else if (sel_addr) rdata = {{(REG_W-PADDR_BITS){1'b0}}, paddr_q};
        else               rdata = '0;
    end

    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:PADDR_BITS];

endmodule

// File: rtl/ecc_inj_fsm.sv
module ecc_inj_fsm
    import ecc_inj_pkg::*;
#(
    parameter int SET_BITS = 8,
    parameter int WAY_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  trig_req_t           trig,
    input  logic                ctrl_rd,
    input  inj_target_e         tgt,
    output logic                busy,
    output inj_status_e         status,
    output inj_reason_e         reason,
    output logic                req_valid,
    input  logic                req_ready,
    input  logic                resp_valid,
    input  logic                resp_hit,
    input  logic [SET_BITS-1:0] resp_set,
    input  logic [WAY_BITS-1:0] resp_way,
    output logic                inj_we,
    output logic                inj_data_sel,
    output logic [SET_BITS-1:0] inj_set,
    output logic [WAY_BITS-1:0] inj_way
);
    typedef enum logic [2:0] {F_IDLE, F_REQ, F_WAIT, F_DONE, F_FAIL} fsm_e;
    fsm_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= F_IDLE;
            reason       <= RSN_NOCHK;
            inj_we       <= 1'b0;
            inj_data_sel <= 1'b0;
            inj_set      <= '0;
            inj_way      <= '0;
        end else begin
            inj_we <= 1'b0;
            unique case (st)
                F_IDLE: if (trig.fire) begin
                    if (!trig.en) begin
                        st     <= F_FAIL;
                        reason <= RSN_NOCHK;
                    end else if (target_reserved(trig.tgt)) begin
                        st     <= F_FAIL;
                        reason <= RSN_BADTGT;
                    end else begin
                        st <= F_REQ;
                    end
                end
                F_REQ: if (req_ready) st <= F_WAIT;
                F_WAIT: if (resp_valid) begin
                    if (resp_hit) begin
                        st           <= F_DONE;
                        inj_we       <= 1'b1;
                        inj_data_sel <= (tgt == TGT_DATA);
                        inj_set      <= resp_set;
                        inj_way      <= resp_way;
                    end else begin
                        st     <= F_FAIL;
                        reason <= RSN_MISS;
                    end
                end
                F_DONE, F_FAIL: if (ctrl_rd) st <= F_IDLE;
                default: st <= F_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            F_REQ, F_WAIT: status = ST_WORK;
            F_DONE:        status = ST_DONE;
            F_FAIL:        status = ST_FAIL;
            default:       status = ST_IDLE;
        endcase
    end

    assign busy      = (st == F_REQ) || (st == F_WAIT);
    assign req_valid = (st == F_REQ);

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int PADDR_BITS = 48,
    parameter int SET_BITS   = 8,
    parameter int WAY_BITS   = 2,
    parameter int OFS_BITS   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [OFS_BITS-1:0]   reg_addr,
    input  logic [63:0]           reg_wdata,
    output logic [63:0]           reg_rdata,
    output logic                  ecc_check_en,
    output logic                  lk_req_valid,
    input  logic                  lk_req_ready,
    output logic [PADDR_BITS-1:0] lk_req_paddr,
    input  logic                  lk_resp_valid,
    input  logic                  lk_resp_hit,
    input  logic [SET_BITS-1:0]   lk_resp_set,
    input  logic [WAY_BITS-1:0]   lk_resp_way,
    output logic                  inj_we,
    output logic                  inj_data_sel,
    output logic [SET_BITS-1:0]   inj_set,
    output logic [WAY_BITS-1:0]   inj_way
);
    trig_req_t             trig;
    logic                  ctrl_rd;
    logic                  busy;
    logic                  en_q;
    inj_target_e           tgt_q;
    logic [PADDR_BITS-1:0] paddr_q;
    inj_status_e           cur_status;
    inj_reason_e           cur_reason;

    ecc_inj_regs #(.PADDR_BITS(PADDR_BITS), .OFS_BITS(OFS_BITS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy), .status(cur_status), .reason(cur_reason),
        .trig(trig), .ctrl_rd(ctrl_rd),
        .en_q(en_q), .tgt_q(tgt_q), .paddr_q(paddr_q)
    );

    ecc_inj_fsm #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) u_fsm (
        .clk(clk), .rst(rst),
        .trig(trig), .ctrl_rd(ctrl_rd), .tgt(tgt_q),
        .busy(busy), .status(cur_status), .reason(cur_reason),
        .req_valid(lk_req_valid), .req_ready(lk_req_ready),
        .resp_valid(lk_resp_valid), .resp_hit(lk_resp_hit),
        .resp_set(lk_resp_set), .resp_way(lk_resp_way),
        .inj_we(inj_we), .inj_data_sel(inj_data_sel),
        .inj_set(inj_set), .inj_way(inj_way)
    );

    assign ecc_check_en = en_q;
    assign lk_req_paddr = paddr_q;

endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk #(
    parameter int PADDR_BITS = 48,
    parameter int OFS_BITS   = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr_en,
    input logic                  reg_rd_en,
    input logic [OFS_BITS-1:0]   reg_addr,
    input logic [63:0]           reg_rdata,
    input logic                  lk_req_valid,
    input logic                  lk_req_ready,
    input logic [PADDR_BITS-1:0] lk_req_paddr,
    input logic                  inj_we,
    input logic [2:0]            status
);
    p_ctrl_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == '0) |-> (reg_rdata[1] == 1'b0 && reg_rdata[63:10] == '0));

    p_status_legal_r11: assert property (@(posedge clk) disable iff (rst)
        (status == 3'd0 || status == 3'd1 || status == 3'd2 || status == 3'd7));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_req_valid && !lk_req_ready) |=> (lk_req_valid && $stable(lk_req_paddr)));

    p_inj_single_r7: assert property (@(posedge clk) disable iff (rst)
        inj_we |=> !inj_we);

    p_inj_status_r7: assert property (@(posedge clk) disable iff (rst)
        inj_we |-> (status == 3'd2));

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && !reg_wr_en && reg_addr == '0 && (status == 3'd2 || status == 3'd7))
        |=> (status == 3'd0));

    p_no_req_unless_working_r10: assert property (@(posedge clk) disable iff (rst)
        (status != 3'd1) |-> !lk_req_valid);

endmodule

bind ecc_inject_ctrl ecc_inj_chk #(.PADDR_BITS(PADDR_BITS), .OFS_BITS(OFS_BITS)) u_chk (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
    .lk_req_paddr(lk_req_paddr), .inj_we(inj_we), .status(cur_status)
);

// File: tb/tb_ecc_inject_ctrl.sv
module tb_ecc_inject_ctrl;
    localparam int PB = 48, SB = 8, WB = 2, OB = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_wr_en = 0, reg_rd_en = 0;
    logic [OB-1:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic ecc_check_en, lk_req_valid, lk_req_ready = 0;
    logic [PB-1:0] lk_req_paddr;
    logic lk_resp_valid = 0, lk_resp_hit = 0;
    logic [SB-1:0] lk_resp_set = '0, inj_set;
    logic [WB-1:0] lk_resp_way = '0, inj_way;
    logic inj_we, inj_data_sel;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ecc_inject_ctrl #(.PADDR_BITS(PB), .SET_BITS(SB), .WAY_BITS(WB), .OFS_BITS(OB)) dut (.*);

    function automatic logic [63:0] ctrl_val(int en, int tgt, int st, int rsn);
        return 64'(en) | (64'(tgt) << 2) | (64'(st) << 4) | (64'(rsn) << 7);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [OB-1:0] a, logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0; reg_wdata = '0;
    endtask

    task automatic rd(logic [OB-1:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_rd_en = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic respond(logic hit, logic [SB-1:0] s, logic [WB-1:0] w);
        lk_req_ready = 1;
        @(negedge clk);
        lk_req_ready = 0;
        lk_resp_valid = 1; lk_resp_hit = hit; lk_resp_set = s; lk_resp_way = w;
        @(negedge clk);
        lk_resp_valid = 0; lk_resp_hit = 0;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(4'h0, d); chk("R1 ctrl", d, 64'h0);
        rd(4'h8, d); chk("R1 addr", d, 64'h0);
        chk("R1 req", lk_req_valid, 0);
        chk("R1 we", inj_we, 0);
        chk("R1 en", ecc_check_en, 0);
    endtask

    task automatic t_layout;
        logic [63:0] d;
        wr(4'h0, 64'hFFFF_FFFF_FFFF_FC09);
        rd(4'h0, d); chk("R2 ctrl bits", d, ctrl_val(1, 2, 0, 0));
        chk("R2 enable pin", ecc_check_en, 1);
        wr(4'h8, 64'hABCD_1234_5678_9ABC);
        rd(4'h8, d); chk("R3 addr low bits", d, 64'h0000_1234_5678_9ABC);
        rd(4'h4, d); chk("R3 other offset", d, 64'h0);
    endtask

    task automatic t_disabled;
        logic [63:0] d;
        wr(4'h0, 64'h6);
        chk("R4 no lookup", lk_req_valid, 0);
        rd(4'h0, d); chk("R4 reason nochk", d, ctrl_val(0, 1, 7, 0));
        rd(4'h0, d); chk("R9 cleared", d, ctrl_val(0, 1, 0, 0));
    endtask

    task automatic t_reserved;
        logic [63:0] d;
        wr(4'h0, 64'hF);
        chk("R5 no lookup", lk_req_valid, 0);
        rd(4'h0, d); chk("R5 reason badtgt", d, ctrl_val(1, 3, 7, 1));
        rd(4'h0, d); chk("R9 cleared", d, ctrl_val(1, 3, 0, 0));
    endtask

    task automatic t_hit(int tgt, logic [SB-1:0] s, logic [WB-1:0] w);
        logic [63:0] d;
        wr(4'h8, 64'h0000_0000_8000_1040);
        wr(4'h0, 64'(3 | (tgt << 2)));
        chk("R6 req valid", lk_req_valid, 1);
        chk("R6 req paddr", 64'(lk_req_paddr), 64'h8000_1040);
        rd(4'h0, d); chk("R6 working", d, ctrl_val(1, tgt, 1, 0));
        @(negedge clk);
        chk("R6 held", lk_req_valid, 1);
        respond(1'b1, s, w);
        chk("R7 strobe", inj_we, 1);
        chk("R7 set", 64'(inj_set), 64'(s));
        chk("R7 way", 64'(inj_way), 64'(w));
        chk("R7 array", inj_data_sel, (tgt == 2));
        @(negedge clk);
        chk("R7 single", inj_we, 0);
        rd(4'h0, d); chk("R7 injected", d, ctrl_val(1, tgt, 2, 0));
        rd(4'h0, d); chk("R9 idle", d, ctrl_val(1, tgt, 0, 0));
    endtask

    task automatic t_miss_busy;
        logic [63:0] d;
        wr(4'h8, 64'h1234);
        wr(4'h0, 64'h3);
        wr(4'h0, 64'h8);
        wr(4'h8, 64'h5678);
        rd(4'h0, d); chk("R10 ctrl held while working", d, ctrl_val(1, 0, 1, 0));
        rd(4'h8, d); chk("R10 addr held while working", d, 64'h1234);
        respond(1'b0, '0, '0);
        chk("R8 no strobe", inj_we, 0);
        @(negedge clk);
        chk("R8 no strobe later", inj_we, 0);
        rd(4'h0, d); chk("R8 miss reason", d, ctrl_val(1, 0, 7, 2));
    endtask

    task automatic t_trig_when_done;
        logic [63:0] d;
        wr(4'h0, 64'hB);
        respond(1'b1, 8'h5A, 2'd1);
        wr(4'h0, 64'h3);
        chk("R10 trigger ignored", lk_req_valid, 0);
        rd(4'h0, d); chk("R10 fields accepted", d, ctrl_val(1, 0, 2, 0));
        rd(4'h0, d); chk("R10 idle", d, ctrl_val(1, 0, 0, 0));
        chk("R10 still no req", lk_req_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_layout;
        t_disabled;
        t_reserved;
        t_hit(0, 8'h3C, 2'd2);
        t_hit(2, 8'hA5, 2'd3);
        t_miss_busy;
        t_trig_when_done;
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule